// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block generates the low-order address bits of a four-beat memory burst. The upper address bits come from elsewhere. When any of its address strobes fires, the block takes a two-bit start value and resets its beat count. Each step pulse after that moves it to the next beat.

A mode input selects one of two beat orders:

- **Sequential order** adds the beat number to the start value, modulo four.
- **Interleaved order** XORs the beat number into the start value.

After the fourth beat, the next step returns to the start value. Both outputs are registered and change on the clock edge that follows the request.

The mode input is normally tied to a fixed level. The block still samples it on every step, so the beat order can change partway through a burst. When that happens, the next address is computed from the captured start value and the new beat number, using the new order.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, `addr_lo_o` and `beat_o` both become 00 after that edge.
- R2: A high `strobe_i[0]` at an edge copies `start_i` into `addr_lo_o` and clears `beat_o` to 00 after that edge.
- R3: A high `strobe_i[1]` loads the burst exactly as `strobe_i[0]` does; any strobe bit set counts as a load.
- R4: With `interleave_i` = 0, a step with no load sets `beat_o` to the old beat plus one (mod 4) and `addr_lo_o` to (start + new beat) mod 4.
- R5: With `interleave_i` = 1, a step with no load sets `beat_o` to the old beat plus one (mod 4) and `addr_lo_o` to start XOR new beat.
- R6: With no strobe and `step_i` low, both outputs keep their values.
- R7: A step taken from beat 3 returns `beat_o` to 00 and `addr_lo_o` to the start value, in either order.
- R8: A strobe and a step in the same cycle act as a load alone, and the step is discarded.
- R9: The order is sampled at each step, so after a change of `interleave_i` partway through a burst the next address follows the new order, using the captured start value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe_i | input | 2 | Address strobes; any set bit loads a new burst |
| start_i | input | 2 | Start value for the low address bits |
| step_i | input | 1 | Advance one beat when high; hold when low |
| interleave_i | input | 1 | 1 = interleaved order, 0 = sequential order |
| addr_lo_o | output | 2 | Current low address bits (registered) |
| beat_o | output | 2 | Beat position within the burst (registered) |

## Verification
The bench looks for the following faults, each with its visible symptom:

- **Wrong order for the mode.** A design that adds where it should XOR shows up at start 01, beat 1. Interleaved order gives 00 and sequential order gives 10.
- **Bad wrap.** A design that stops at beat 3, or wraps somewhere other than the captured start value, fails the fifth-beat check.
- **Step beats load.** A design that lets a simultaneous step win over a load produces beat 01 instead of 00.
- **Mode latched at load time.** A design that fixes the order at load time misses the mid-burst mode change: from start 01, beat 3 gives 10 in interleaved order but 00 in sequential order.

Seeded random traffic then mixes both strobes, holds and wraps against a model kept inside the bench.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  typedef enum logic {
    ORD_SEQUENTIAL  = 1'b0,
    ORD_INTERLEAVED = 1'b1
  } burst_order_e;
endpackage

// File: rtl/burst_strobe_merge.sv
module burst_strobe_merge #(
  parameter int N_STROBE = 2
) (
  input  logic [N_STROBE-1:0] strobe_i,
  output logic                load_o
);
  logic [N_STROBE:0] chain;
  assign chain[0] = 1'b0;
  for (genvar g = 0; g < N_STROBE; g++) begin : g_or
    assign chain[g+1] = chain[g] | strobe_i[g];
  end
  assign load_o = chain[N_STROBE];
endmodule

// File: rtl/burst_step_calc.sv
module burst_step_calc
  import burst_addr_pkg::*;
#(
  parameter int OFS_W = 2
) (
  input  logic [OFS_W-1:0] start_i,
  input  logic [OFS_W-1:0] beat_i,
  input  burst_order_e     order_i,
  output logic [OFS_W-1:0] addr_o
);
  logic [OFS_W-1:0] seq_addr;
  logic [OFS_W-1:0] ilv_addr;

  assign seq_addr = start_i + beat_i;
  assign ilv_addr = start_i ^ beat_i;

  always_comb begin
    case (order_i)
      ORD_INTERLEAVED: addr_o = ilv_addr;
      default:         addr_o = seq_addr;
    endcase
  end
endmodule

// File: rtl/burst_state_reg.sv
module burst_state_reg #(
  parameter int OFS_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [OFS_W-1:0] start_i,
  input  logic [OFS_W-1:0] addr_nxt_i,
  output logic [OFS_W-1:0] start_q_o,
  output logic [OFS_W-1:0] beat_q_o,
  output logic [OFS_W-1:0] beat_nxt_o,
  output logic [OFS_W-1:0] addr_q_o
);
  logic [OFS_W-1:0] start_q;
  logic [OFS_W-1:0] beat_q;
  logic [OFS_W-1:0] addr_q;

  assign beat_nxt_o = beat_q + OFS_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      beat_q  <= '0;
      addr_q  <= '0;
    end else if (load_i) begin
      start_q <= start_i;
      beat_q  <= '0;
      addr_q  <= start_i;
    end else if (step_i) begin
      beat_q  <= beat_nxt_o;
      addr_q  <= addr_nxt_i;
    end
  end

  assign start_q_o = start_q;
  assign beat_q_o  = beat_q;
  assign addr_q_o  = addr_q;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int OFS_W    = 2,
  parameter int N_STROBE = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_STROBE-1:0] strobe_i,
  input  logic [OFS_W-1:0]    start_i,
  input  logic                step_i,
  input  logic                interleave_i,
  output logic [OFS_W-1:0]    addr_lo_o,
  output logic [OFS_W-1:0]    beat_o
);
  logic             load;
  logic [OFS_W-1:0] start_q;
  logic [OFS_W-1:0] beat_q;
  logic [OFS_W-1:0] beat_nxt;
  logic [OFS_W-1:0] addr_nxt;
  logic [OFS_W-1:0] addr_q;
  burst_order_e     order;

  assign order = interleave_i ? ORD_INTERLEAVED : ORD_SEQUENTIAL;

  burst_strobe_merge #(.N_STROBE(N_STROBE)) u_merge (
    .strobe_i (strobe_i),
    .load_o   (load)
  );

  burst_step_calc #(.OFS_W(OFS_W)) u_calc (
    .start_i (start_q),
    .beat_i  (beat_nxt),
    .order_i (order),
    .addr_o  (addr_nxt)
  );

  burst_state_reg #(.OFS_W(OFS_W)) u_state (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load),
    .step_i     (step_i),
    .start_i    (start_i),
    .addr_nxt_i (addr_nxt),
    .start_q_o  (start_q),
    .beat_q_o   (beat_q),
    .beat_nxt_o (beat_nxt),
    .addr_q_o   (addr_q)
  );

  assign addr_lo_o = addr_q;
  assign beat_o    = beat_q;
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int OFS_W    = 2,
  parameter int N_STROBE = 2
) (
  input logic                clk,
  input logic                rst,
  input logic [N_STROBE-1:0] strobe_i,
  input logic [OFS_W-1:0]    start_i,
  input logic                step_i,
  input logic                interleave_i,
  input logic [OFS_W-1:0]    addr_lo_o,
  input logic [OFS_W-1:0]    beat_o
);
  logic             ld;
  logic [OFS_W-1:0] ref_start;

  assign ld = |strobe_i;

  always_ff @(posedge clk) begin
    if (rst)     ref_start <= '0;
    else if (ld) ref_start <= start_i;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (addr_lo_o == '0) && (beat_o == '0));

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (rst)
    ld |=> (addr_lo_o == $past(start_i)) && (beat_o == '0));

  // R8
  load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (ld && step_i) |=> (beat_o == '0));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ld && !step_i) |=> $stable(addr_lo_o) && $stable(beat_o));

  // R4
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!ld && step_i && !interleave_i) |=> (beat_o == $past(beat_o) + OFS_W'(1))
      && (addr_lo_o == OFS_W'(ref_start + beat_o)));

  // R5
  ilv_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!ld && step_i && interleave_i) |=> (beat_o == $past(beat_o) + OFS_W'(1))
      && (addr_lo_o == (ref_start ^ beat_o)));

  // R7
  wrap_start_chk: assert property (@(posedge clk) disable iff (rst)
    (!ld && step_i && (beat_o == '1)) |=> (beat_o == '0) && (addr_lo_o == ref_start));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.OFS_W(OFS_W), .N_STROBE(N_STROBE)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .strobe_i     (strobe_i),
  .start_i      (start_i),
  .step_i       (step_i),
  .interleave_i (interleave_i),
  .addr_lo_o    (addr_lo_o),
  .beat_o       (beat_o)
);

// File: tb/burst_addr_gen_test.sv
`timescale 1ns/1ps
module burst_addr_gen_test;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] strobe;
  logic [1:0] start;
  logic       step;
  logic       ilv;
  logic [1:0] addr;
  logic [1:0] beat;

  int n_chk  = 0;
  int n_fail = 0;

  logic [1:0] m_start = 2'b00;
  logic [1:0] m_beat  = 2'b00;
  logic [1:0] m_addr  = 2'b00;

  always #2 clk = ~clk;

  burst_addr_gen uut (
    .clk          (clk),
    .rst          (rst),
    .strobe_i     (strobe),
    .start_i      (start),
    .step_i       (step),
    .interleave_i (ilv),
    .addr_lo_o    (addr),
    .beat_o       (beat)
  );

  function automatic logic [1:0] exp_addr(input logic [1:0] s, input logic [1:0] b,
                                          input logic il);
    logic [1:0] r;
    if (il) r = s ^ b;
    else    r = 2'((s + b) & 2'b11);
    return r;
  endfunction

  task automatic check(input string req);
    n_chk++;
    if (addr !== m_addr || beat !== m_beat) begin
      n_fail++;
      $display("FAIL %s: addr=%b beat=%b expected addr=%b beat=%b",
               req, addr, beat, m_addr, m_beat);
    end
  endtask

  task automatic cyc(input logic [1:0] stb, input logic [1:0] st, input logic stp,
                     input logic il, input string req);
    strobe = stb; start = st; step = stp; ilv = il;
    @(posedge clk);
    if (stb != 2'b00) begin
      m_start = st; m_beat = 2'b00; m_addr = st;
    end else if (stp) begin
      m_beat = m_beat + 2'b01;
      m_addr = exp_addr(m_start, m_beat, il);
    end
    @(negedge clk);
    check(req);
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_up();
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd9137);
    rst = 1'b1; strobe = 2'b00; start = 2'b11; step = 1'b1; ilv = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    m_start = 2'b00; m_beat = 2'b00; m_addr = 2'b00;
    check("R1");
    rst = 1'b0;

    // R2 + R4 + R7: sequential from 01 through wrap
    cyc(2'b01, 2'b01, 1'b0, 1'b0, "R2");
    for (int i = 0; i < 4; i++) cyc(2'b00, 2'b00, 1'b1, 1'b0, (i == 3) ? "R7" : "R4");
    // R3 + R5 + R7: interleaved from 10 via second strobe
    cyc(2'b10, 2'b10, 1'b0, 1'b1, "R3");
    for (int i = 0; i < 4; i++) cyc(2'b00, 2'b00, 1'b1, 1'b1, (i == 3) ? "R7" : "R5");
    // R6: hold
    cyc(2'b00, 2'b00, 1'b1, 1'b1, "R5");
    for (int i = 0; i < 3; i++) cyc(2'b00, 2'b01, 1'b0, 1'b0, "R6");
    // R8: load and step together
    cyc(2'b11, 2'b11, 1'b1, 1'b0, "R8");
    // R5 vs R4 distinction: start 01 step once interleaved -> 00
    cyc(2'b01, 2'b01, 1'b0, 1'b1, "R2");
    cyc(2'b00, 2'b00, 1'b1, 1'b1, "R5");
    // R9: mode switch at beat 3, start 01 -> 10 (seq would give 00)
    cyc(2'b10, 2'b01, 1'b0, 1'b0, "R3");
    cyc(2'b00, 2'b00, 1'b1, 1'b0, "R4");
    cyc(2'b00, 2'b00, 1'b1, 1'b0, "R4");
    cyc(2'b00, 2'b00, 1'b1, 1'b1, "R9");

    for (int i = 0; i < 3000; i++) begin
      logic [1:0] stb;
      logic       stp;
      logic       il;
      string      tag;
      stb = ($urandom_range(0, 5) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
      stp = 1'($urandom_range(0, 1));
      il  = ($urandom_range(0, 15) == 0) ? ~ilv : ilv;
      if (stb != 2'b00 && stp) tag = "R8";
      else if (stb == 2'b10)   tag = "R3";
      else if (stb != 2'b00)   tag = "R2";
      else if (!stp)           tag = "R6";
      else if (m_beat == 2'b11) tag = "R7";
      else if (il)             tag = "R5";
      else                     tag = "R4";
      cyc(stb, 2'($urandom_range(0, 3)), stp, il, tag);
    end
    finish_up();
  end
endmodule